// File: doc/BRIEF.md
# Audio Serial Port Register Block

This block is the software-facing register file of an audio serial port. It holds one control word and one status word on a simple 32-bit read/write bus. Each word can be reached at three addresses. A write to the plain address replaces the word. A write to the set alias turns on the bits that are 1 in the data. A write to the clear alias turns off the bits that are 1 in the data. The aliases let software start and stop the port, or acknowledge errors, without a read-modify-write sequence.

The control word holds these fields:
- a soft reset and a clock gate, both asserted out of reset;
- a run bit;
- a FIFO-error interrupt enable;
- a transfer direction;
- the frame-format and clock-rate fields that the serializer and the divider decode.

The status word holds a busy flag, read live from the serializer, and two sticky flags for FIFO underflow and FIFO overflow. The sticky flags drive the interrupt line.

A small port state machine follows the control word and drives `port_on`, which enables the serializer. Its states are:
- **HELD**: soft reset is set.
- **GATED**: soft reset is clear and the clock gate is set.
- **IDLE**: the port is open but not running.
- **ACTIVE**: the port is running.
- **DRAIN**: run has been cleared, but the serializer still reports busy.

Its transitions are:
- **hold**: any state goes to HELD when soft reset is set.
- **gate**: any state goes to GATED when the gate is set and soft reset is clear.
- **open**: HELD or GATED goes to IDLE, or straight to ACTIVE when run is set.
- **start**: IDLE goes to ACTIVE.
- **stop**: ACTIVE goes to DRAIN when busy, otherwise to IDLE.
- **settle**: DRAIN goes to IDLE when busy drops.
- **resume**: DRAIN goes to ACTIVE when run is set again.

Top module: `sap_regs`

## Requirements
- R1: After reset the control word reads 0xC000_0000, with soft reset (bit 31) and clock gate (bit 30) set. The status word reads 0 while `busy_in` is low, and `irq` and `port_on` are low.
- R2: A write to the control base address 0x00 replaces every implemented control bit. The implemented bits are 31, 30 and 15..0. Unimplemented bits always read 0.
- R3: A write to the control set alias 0x04 ORs the write data into the control word.
- R4: A write to the control clear alias 0x08 clears the control bits that are 1 in the write data and keeps the others.
- R5: While soft reset is set, every control bit other than bits 31 and 30 reads 0, whatever is written.
- R6: Status bit 0 (busy) always equals `busy_in`. Writes at 0x10, 0x14 and 0x18 do not change it.
- R7: Status bit 1 (underflow) and status bit 2 (overflow) become 1 on the edge after their event input is high. They stay 1 after the event drops, and writes to status base 0x10 or status set 0x14 do not change them.
- R8: A 1 at a flag's position written to the status clear alias 0x18 clears that flag. A 0 leaves the flag as it was.
- R9: If an event and a clear-alias write for the same flag fall on one edge, the flag ends up set.
- R10: `irq` is high exactly when control bit 2 (interrupt enable) is set and at least one sticky flag is set.
- R11: `port_on` rises on the edge after the control word holds run (bit 0) = 1 with bits 31 and 30 clear.
- R12: When run is cleared while `busy_in` is high, `port_on` stays high until the edge after `busy_in` falls.
- R13: Setting soft reset or clock gate drops `port_on` on the next edge, even while `busy_in` is high.
- R14: Writes to offset 0x0C or 0x1C change nothing, and reads there return 0. Reads at either alias return the word itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bit 4 selects control (0) or status (1); bits 3:2 select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is selected |
| busy_in | input | 1 | Serializer activity |
| underflow_evt | input | 1 | FIFO underflow event |
| overflow_evt | input | 1 | FIFO overflow event |
| ctrl_word | output | 32 | Current control word, for the serializer and the divider |
| port_on | output | 1 | Serializer enable from the port state machine |
| irq | output | 1 | FIFO-error interrupt |

## Verification
Two pairs of functions can meet on the same edge. The first pair is a hardware FIFO event and a software acknowledge of that flag through the status clear alias. The bench raises `overflow_evt` in the very cycle it writes a 1 to the overflow position at 0x18, then reads the status back and expects the flag still set. The second pair is a stop request, which clears run, and continuing serializer activity. The bench holds `busy_in` high across the stop and watches `port_on` stay high through the drain state. It then expects `port_on` to fall exactly one edge after `busy_in` falls. A checker also watches, on every cycle, that a flag never drops without a matching clear.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int unsigned DW = 32;
    typedef logic [DW-1:0] word_t;

    // control bit positions decoded by neighbouring logic
    localparam int unsigned B_RUN     = 0;
    localparam int unsigned B_CAPTURE = 1;
    localparam int unsigned B_IEN     = 2;
    localparam int unsigned B_GATE    = 30;
    localparam int unsigned B_SRST    = 31;

    // status bit positions
    localparam int unsigned S_BUSY  = 0;
    localparam int unsigned S_FLAG0 = 1;

    localparam word_t KEEP_IN_SRST = (word_t'(1) << B_SRST) | (word_t'(1) << B_GATE);

    typedef enum logic [1:0] {OP_NONE, OP_BASE, OP_SET, OP_CLR} op_e;

    typedef enum logic [2:0] {ST_HELD, ST_GATED, ST_IDLE, ST_ACTIVE, ST_DRAIN} port_st_e;

    function automatic word_t apply_op(op_e op, word_t cur, word_t wd);
        word_t r;
        unique case (op)
            OP_BASE: r = wd;
            OP_SET:  r = cur | wd;
            OP_CLR:  r = cur & ~wd;
            default: r = cur;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sap_addr_dec.sv
module sap_addr_dec
    import sap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output op_e               ctl_op,
    output op_e               stat_op,
    output logic              rd_ctl,
    output logic              rd_stat
);
    localparam int unsigned LO_W = 2;

    logic            hi_ok;
    logic            mapped;
    logic [1:0]      offs;
    logic [LO_W-1:0] unused_lo;
    op_e             op;

    generate
        if (ADDR_W > 5) begin : g_hi
            assign hi_ok = ~|addr[ADDR_W-1:5];
        end else begin : g_nohi
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign unused_lo = addr[LO_W-1:0];
    assign offs      = addr[3:2];
    assign mapped    = hi_ok && (offs != 2'b11);

    always_comb begin
        unique case (offs)
            2'b00:   op = OP_BASE;
            2'b01:   op = OP_SET;
            2'b10:   op = OP_CLR;
            default: op = OP_NONE;
        endcase
    end

    assign ctl_op  = (sel && wr && mapped && !addr[4]) ? op : OP_NONE;
    assign stat_op = (sel && wr && mapped &&  addr[4]) ? op : OP_NONE;
    assign rd_ctl  = sel && !wr && mapped && !addr[4];
    assign rd_stat = sel && !wr && mapped &&  addr[4];
endmodule

// File: rtl/sap_ctrl_reg.sv
module sap_ctrl_reg
    import sap_pkg::*;
#(
    parameter word_t MASK  = 32'hC000_FFFF,
    parameter word_t RSTVAL = 32'hC000_0000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  op_e   op,
    input  word_t wdata,
    output word_t q
);
    localparam word_t RST_EFF = RSTVAL & MASK;

    word_t nxt;

    always_comb begin
        nxt = apply_op(op, q, wdata) & MASK;
        if (nxt[B_SRST]) begin
            nxt = nxt & KEEP_IN_SRST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_EFF;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/sap_stat_reg.sv
module sap_stat_reg
    import sap_pkg::*;
#(
    parameter int unsigned NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [NFLAG-1:0] clr_bits,
    input  logic [NFLAG-1:0] evt,
    output logic [NFLAG-1:0] flags
);
    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (evt[i]) begin
                    flags[i] <= 1'b1;
                end else if (op == OP_CLR && clr_bits[i]) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sap_port_fsm.sv
module sap_port_fsm
    import sap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     srst,
    input  logic     gate,
    input  logic     run,
    input  logic     busy,
    output port_st_e state_q,
    output logic     port_on
);
    port_st_e nxt;

    always_comb begin
        nxt = state_q;
        if (srst) begin
            nxt = ST_HELD;
        end else if (gate) begin
            nxt = ST_GATED;
        end else begin
            unique case (state_q)
                ST_HELD, ST_GATED: nxt = run ? ST_ACTIVE : ST_IDLE;
                ST_IDLE:           nxt = run ? ST_ACTIVE : ST_IDLE;
                ST_ACTIVE:         nxt = run ? ST_ACTIVE : (busy ? ST_DRAIN : ST_IDLE);
                ST_DRAIN:          nxt = run ? ST_ACTIVE : (busy ? ST_DRAIN : ST_IDLE);
                default:           nxt = ST_HELD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= nxt;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ACTIVE, ST_DRAIN: port_on = 1'b1;
            default:             port_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/sap_regs.sv
module sap_regs
    import sap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter logic [31:0] CTRL_MASK = 32'hC000_FFFF,
    parameter logic [31:0] CTRL_RST  = 32'hC000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy_in,
    input  logic              underflow_evt,
    input  logic              overflow_evt,
    output logic [31:0]       ctrl_word,
    output logic              port_on,
    output logic              irq
);
    localparam int unsigned NFLAG = 2;

    op_e              ctl_op;
    op_e              stat_op;
    logic             rd_ctl;
    logic             rd_stat;
    word_t            ctrl_q;
    word_t            stat_word;
    logic [NFLAG-1:0] flags_q;
    port_st_e         port_state;

    sap_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .ctl_op  (ctl_op),
        .stat_op (stat_op),
        .rd_ctl  (rd_ctl),
        .rd_stat (rd_stat)
    );

    sap_ctrl_reg #(.MASK(CTRL_MASK), .RSTVAL(CTRL_RST)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ctl_op),
        .wdata (bus_wdata),
        .q     (ctrl_q)
    );

    sap_stat_reg #(.NFLAG(NFLAG)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (stat_op),
        .clr_bits (bus_wdata[S_FLAG0 +: NFLAG]),
        .evt      ({overflow_evt, underflow_evt}),
        .flags    (flags_q)
    );

    sap_port_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (ctrl_q[B_SRST]),
        .gate    (ctrl_q[B_GATE]),
        .run     (ctrl_q[B_RUN]),
        .busy    (busy_in),
        .state_q (port_state),
        .port_on (port_on)
    );

    always_comb begin
        stat_word                   = '0;
        stat_word[S_BUSY]           = busy_in;
        stat_word[S_FLAG0 +: NFLAG] = flags_q;
    end

    always_comb begin
        if (rd_ctl) begin
            bus_rdata = ctrl_q;
        end else if (rd_stat) begin
            bus_rdata = stat_word;
        end else begin
            bus_rdata = '0;
        end
    end

    assign ctrl_word = ctrl_q;
    assign irq       = ctrl_q[B_IEN] & (|flags_q);
endmodule

// File: rtl/sap_regs_chk.sv
module sap_regs_chk
    import sap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy_in,
    input logic              underflow_evt,
    input logic              overflow_evt,
    input logic [31:0]       ctrl_q,
    input logic [1:0]        flags_q,
    input port_st_e          port_state,
    input logic              port_on,
    input logic              irq
);
    logic clr_stat;
    logic set_ctl;

    assign clr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(5'h18));
    assign set_ctl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(5'h04));

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(clr_stat && bus_wdata[1])) |=> flags_q[0]);      // R7

    AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[1] && !(clr_stat && bus_wdata[2])) |=> flags_q[1]);      // R7

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_evt || overflow_evt) |=> (flags_q != 2'b00));           // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[2] |-> !irq);                                              // R10

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[31] |-> ((ctrl_q & 32'h3FFF_FFFF) == 32'h0));               // R5

    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ctl && !ctrl_q[31] && !bus_wdata[31])
        |=> ((ctrl_q & $past(bus_wdata & 32'hC000_FFFF)) == $past(bus_wdata & 32'hC000_FFFF))); // R3

    AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[31]) || $past(ctrl_q[30])) |-> !port_on);           // R13

    AST_DRAIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == ST_DRAIN) |-> $past(busy_in));                      // R12
endmodule

bind sap_regs sap_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .busy_in       (busy_in),
    .underflow_evt (underflow_evt),
    .overflow_evt  (overflow_evt),
    .ctrl_q        (ctrl_q),
    .flags_q       (flags_q),
    .port_state    (port_state),
    .port_on       (port_on),
    .irq           (irq)
);

// File: tb/sap_regs_bench.sv
module sap_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy_in = 1'b0;
    logic        underflow_evt = 1'b0;
    logic        overflow_evt = 1'b0;
    logic [31:0] ctrl_word;
    logic        port_on;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sap_regs u_sap_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .busy_in       (busy_in),
        .underflow_evt (underflow_evt),
        .overflow_evt  (overflow_evt),
        .ctrl_word     (ctrl_word),
        .port_on       (port_on),
        .irq           (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl reset", 5'h00, 32'hC000_0000);
        rd_chk("R1 stat reset", 5'h10, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 port_on reset", {31'b0, port_on}, 32'h0);
    endtask

    task automatic t_srst_hold;
        wr(5'h04, 32'h0000_0F05);
        rd_chk("R5 set ignored in soft reset", 5'h00, 32'hC000_0000);
        wr(5'h00, 32'h8000_FFFF);
        rd_chk("R5 base ignored in soft reset", 5'h00, 32'h8000_0000);
        wr(5'h00, 32'hC000_0000);
        wr(5'h08, 32'h8000_0000);
        rd_chk("R4 clear soft reset", 5'h00, 32'h4000_0000);
        wr(5'h04, 32'h0000_0001);
        rd_chk("R3 run set while gated", 5'h04, 32'h4000_0001);
        @(negedge clk);
        chk("R13 gated keeps port off", {31'b0, port_on}, 32'h0);
    endtask

    task automatic t_base;
        wr(5'h00, 32'h3FFF_ABCD);
        rd_chk("R2 base replaces, unimplemented read 0", 5'h00, 32'h0000_ABCD);
        chk("R2 ctrl_word output", ctrl_word, 32'h0000_ABCD);
        chk("R11 port_on after run", {31'b0, port_on}, 32'h1);
    endtask

    task automatic t_set_clr;
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0000_0102);
        rd_chk("R3 set alias or", 5'h00, 32'h0000_0102);
        wr(5'h04, 32'h0000_0010);
        rd_chk("R3 set alias accumulates", 5'h08, 32'h0000_0112);
        wr(5'h08, 32'h0000_0002);
        rd_chk("R4 clear alias", 5'h00, 32'h0000_0110);
        wr(5'h08, 32'h0);
        rd_chk("R4 clear zero keeps", 5'h00, 32'h0000_0110);
    endtask

    task automatic t_unmapped;
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_chk("R14 unmapped write ignored", 5'h00, 32'h0000_0110);
        rd_chk("R14 stat unchanged", 5'h10, 32'h0);
        busy_in = 1'b1;
        rd_chk("R14 unmapped reads 0", 5'h1C, 32'h0);
        busy_in = 1'b0;
    endtask

    task automatic t_busy;
        busy_in = 1'b1;
        rd_chk("R6 busy reflects input", 5'h10, 32'h1);
        wr(5'h10, 32'h0);
        wr(5'h18, 32'h1);
        rd_chk("R6 busy ignores writes", 5'h14, 32'h1);
        busy_in = 1'b0;
        wr(5'h14, 32'h1);
        rd_chk("R6 busy follows input low", 5'h10, 32'h0);
    endtask

    task automatic t_sticky;
        @(negedge clk); underflow_evt = 1'b1;
        @(negedge clk); underflow_evt = 1'b0;
        rd_chk("R7 underflow sticky", 5'h10, 32'h2);
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h4);
        rd_chk("R7 base and set do not touch flags", 5'h10, 32'h2);
        chk("R10 irq off without enable", {31'b0, irq}, 32'h0);
        wr(5'h04, 32'h0000_0004);
        chk("R10 irq with enable and flag", {31'b0, irq}, 32'h1);
        wr(5'h18, 32'h4);
        rd_chk("R8 other flag bit leaves underflow", 5'h10, 32'h2);
        wr(5'h18, 32'h2);
        rd_chk("R8 clear alias clears underflow", 5'h10, 32'h0);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        overflow_evt = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h4;
        @(negedge clk);
        overflow_evt = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R9 event wins over clear", 5'h10, 32'h4);
        chk("R10 irq on overflow", {31'b0, irq}, 32'h1);
        wr(5'h18, 32'h4);
        rd_chk("R8 overflow cleared", 5'h10, 32'h0);
    endtask

    task automatic t_drain;
        wr(5'h00, 32'h0);
        @(negedge clk);
        chk("R11 port off when idle", {31'b0, port_on}, 32'h0);
        busy_in = 1'b1;
        wr(5'h04, 32'h1);
        @(negedge clk);
        chk("R11 port on after start", {31'b0, port_on}, 32'h1);
        wr(5'h08, 32'h1);
        @(negedge clk);
        chk("R12 drain holds port on", {31'b0, port_on}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R12 still draining", {31'b0, port_on}, 32'h1);
        busy_in = 1'b0;
        chk("R12 not dropped before edge", {31'b0, port_on}, 32'h1);
        @(negedge clk);
        chk("R12 port off after busy falls", {31'b0, port_on}, 32'h0);
    endtask

    task automatic t_gate_abrupt;
        busy_in = 1'b1;
        wr(5'h04, 32'h1);
        @(negedge clk);
        chk("R11 restart", {31'b0, port_on}, 32'h1);
        wr(5'h04, 32'h4000_0000);
        @(negedge clk);
        chk("R13 gate drops port while busy", {31'b0, port_on}, 32'h0);
        rd_chk("R3 run kept under gate", 5'h00, 32'h4000_0001);
        wr(5'h08, 32'h4000_0000);
        @(negedge clk);
        chk("R11 reopen with run", {31'b0, port_on}, 32'h1);
        wr(5'h04, 32'h8000_0000);
        @(negedge clk);
        chk("R13 soft reset drops port", {31'b0, port_on}, 32'h0);
        rd_chk("R5 soft reset clears fields", 5'h00, 32'h8000_0000);
        busy_in = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_srst_hold;
        t_base;
        t_set_clr;
        t_unmapped;
        t_busy;
        t_sticky;
        t_collide;
        t_drain;
        t_gate_abrupt;
        finish_run;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule